// File: doc/BRIEF.md
# Serial Port Register and FIFO Front End

This block is the software-facing side of a byte-oriented asynchronous serial port. It sits on a 32-bit processor bus with per-byte write enables, in a 256-byte window. Software uses it to configure the port, queue bytes for transmission, collect received bytes, reset either queue, and manage interrupt status. The block does not shift bits onto a wire. Transmit bytes leave through a byte stream with valid and ready, toward a serializer elsewhere. Received bytes arrive on a second byte stream from a deserializer.

Six control and status words are held in registers. Each of them applies its own write mask. Two queues of eight bytes buffer traffic in each direction. Two status flags record that receive data is waiting and that the transmit queue has drained. The hardware sets these flags and only software clears them. A single level interrupt is raised while any enabled flag is set. Byte lanes are big-endian, so the lane at byte offset 0 is bits 31:24. Queue data always moves through that lane.

Top module: `sio_port_regs`

## Requirements
- R1: After reset, these words read as follows: line control 0x40000000, baud control 0x03FF0000, line status 0, interrupt control 0, and FIFO control 0. Both queues are empty, `irq` and `dma_err` are low, and `rx_ready` is high.
- R2: A write stores the old word merged with the write data and then ANDed with that register's mask. The masks are: line control (0x00) 0xE17F0000, interrupt control (0x08) 0x000F0000, interrupt status (0x0C) 0x00070000, FIFO control (0x10) 0x001F0000, and baud control (0x14) 0x03FF0000. Writes to line status (0x04) have no effect.
- R3: `bus_be[3]` enables bits 31:24 (byte offset 0) and `bus_be[0]` enables bits 7:0. A write leaves lanes whose enable is clear unchanged.
- R4: A write to 0x20 with `bus_be[3]` set pushes `bus_wdata[31:24]` into the transmit queue. A write to 0x20 without `bus_be[3]` pushes nothing. A read of 0x20 returns 0.
- R5: A read of 0x30 with `bus_be[3]` set pops the head of the receive queue and returns it in bits 31:24, with the other bits 0. It returns 0 when the queue is empty. A read without `bus_be[3]` returns 0 and pops nothing.
- R6: Interrupt status bit 16 is set in every cycle in which the receive queue holds data. Bit 17 is set in every cycle in which the transmit queue is empty. A software write can clear a bit, but a bit whose condition still holds is set again in the same update.
- R7: `irq` is a register. It is high exactly when (interrupt status AND interrupt control) has any of bits 18:16 set, and it follows the registers on the same clock edge. It can only fall after a software write.
- R8: A FIFO control write whose stored value has bit 16 set empties the transmit queue if bit 18 is set, and empties the receive queue if bit 17 is set. When bit 16 is clear, bits 17 and 18 empty nothing.
- R9: Each queue holds 8 bytes. A transmit push while the queue is full is dropped and sets line status bit 0. That bit stays set until reset or until the transmit queue is reset.
- R10: `tx_valid` is high while the transmit queue holds data. `tx_data` is the oldest byte, and a byte is removed when `tx_valid` and `tx_ready` are both high. Bytes leave in push order.
- R11: `rx_ready` is high while the receive queue is not full. A byte is stored when `rx_valid` and `rx_ready` are both high, and bytes are popped in arrival order.
- R12: `dma_err` is a register that equals interrupt control bit 19 (DMA request, unsupported). It flags that software has asked for DMA.
- R13: `bus_rdata` is registered and valid in the cycle after the read. An access with `bus_addr[1:0]` nonzero, or to an unmapped word, reads 0 and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address within the window |
| bus_be | input | 4 | Byte enables; bit 3 = bits 31:24 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the read |
| irq | output | 1 | Level interrupt |
| dma_err | output | 1 | DMA requested (unsupported) |
| tx_data | output | 8 | Transmit head byte |
| tx_valid | output | 1 | Transmit byte available |
| tx_ready | input | 1 | Serializer takes the byte |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | Received byte offered |
| rx_ready | output | 1 | Receive queue has room |

## Verification
Each queue has a bus side and a stream side, and the two sides can act in the same cycle. The bench provokes this on the receive queue: one clock edge carries both a stream byte arriving and a bus read that pops. On the transmit queue it provokes the mirror case, a bus push on the same edge as a stream pop. It then judges the result by the order and values of the bytes read back or drained afterward, and by the queue being empty at the end. Sticky status flags meeting a software clear in the same update is a second collision. It is judged through `irq` and the status word.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int WORD_W = 32;
  localparam int LANES  = WORD_W / 8;

  // word indices (byte address / 4)
  localparam int IDX_LINE_CTL = 'h00;
  localparam int IDX_LINE_STS = 'h01;
  localparam int IDX_INT_CTL  = 'h02;
  localparam int IDX_INT_STS  = 'h03;
  localparam int IDX_FIFO_CTL = 'h04;
  localparam int IDX_BAUD     = 'h05;
  localparam int IDX_TX_DATA  = 'h08;
  localparam int IDX_RX_DATA  = 'h0C;

  localparam logic [WORD_W-1:0] MASK_LINE_CTL = 32'hE17F_0000;
  localparam logic [WORD_W-1:0] MASK_INT_CTL  = 32'h000F_0000;
  localparam logic [WORD_W-1:0] MASK_INT_STS  = 32'h0007_0000;
  localparam logic [WORD_W-1:0] MASK_FIFO_CTL = 32'h001F_0000;
  localparam logic [WORD_W-1:0] MASK_BAUD     = 32'h03FF_0000;
  localparam logic [WORD_W-1:0] IRQ_SRC_MASK  = 32'h0007_0000;

  localparam logic [WORD_W-1:0] RST_LINE_CTL = 32'h4000_0000;
  localparam logic [WORD_W-1:0] RST_BAUD     = 32'h03FF_0000;

  localparam int BIT_RX_DATA = 16;
  localparam int BIT_TX_EMPTY = 17;
  localparam int BIT_DMA_REQ = 19;
  localparam int BIT_FRST_EN = 16;
  localparam int BIT_RX_FLUSH = 17;
  localparam int BIT_TX_FLUSH = 18;

  function automatic logic [WORD_W-1:0] merge_lanes(
    input logic [WORD_W-1:0] old_v,
    input logic [WORD_W-1:0] new_v,
    input logic [LANES-1:0]  be,
    input logic [WORD_W-1:0] mask);
    logic [WORD_W-1:0] r;
    for (int i = 0; i < LANES; i++)
      r[8*i +: 8] = be[i] ? new_v[8*i +: 8] : old_v[8*i +: 8];
    return r & mask;
  endfunction
endpackage

// File: rtl/sio_byte_fifo.sv
module sio_byte_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count;
  logic             do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rd_ptr];

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // storage without reset so it can map to RAM
  always_ff @(posedge clk)
    if (do_push) mem[wr_ptr] <= push_data;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= step(wr_ptr);
      if (do_pop)  rd_ptr <= step(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: ;
      endcase
    end
  end

  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (rst)
    flush |=> empty);
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop && !flush) |=> full);
endmodule

// File: rtl/sio_irq_unit.sv
module sio_irq_unit
  import sio_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_wr,
  input  logic              sts_wr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [LANES-1:0]  be,
  input  logic              rx_has_data,
  input  logic              tx_is_empty,
  output logic [WORD_W-1:0] ctl_q,
  output logic [WORD_W-1:0] sts_q,
  output logic              irq,
  output logic              dma_err
);
  logic [WORD_W-1:0] ctl_d, sts_d, hw_set;

  always_comb begin
    ctl_d = ctl_wr ? merge_lanes(ctl_q, wdata, be, MASK_INT_CTL) : ctl_q;
    hw_set = '0;
    hw_set[BIT_RX_DATA]  = rx_has_data;
    hw_set[BIT_TX_EMPTY] = tx_is_empty;
    sts_d = (sts_wr ? merge_lanes(sts_q, wdata, be, MASK_INT_STS) : sts_q) | hw_set;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q   <= '0;
      sts_q   <= '0;
      irq     <= 1'b0;
      dma_err <= 1'b0;
    end else begin
      ctl_q   <= ctl_d;
      sts_q   <= sts_d;
      irq     <= |(ctl_d & sts_d & IRQ_SRC_MASK);
      dma_err <= ctl_d[BIT_DMA_REQ];
    end
  end

  assert_irq_falls_on_write_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(irq) |-> $past(ctl_wr || sts_wr));
  assert_rx_flag_sets_R6: assert property (@(posedge clk) disable iff (rst)
    rx_has_data |=> sts_q[BIT_RX_DATA]);
  assert_rx_flag_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (sts_q[BIT_RX_DATA] && !sts_wr) |=> sts_q[BIT_RX_DATA]);
endmodule

// File: rtl/sio_port_regs.sv
module sio_port_regs
  import sio_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int FIFO_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [LANES-1:0]  bus_be,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              irq,
  output logic              dma_err,
  output logic [7:0]        tx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  input  logic [7:0]        rx_data,
  input  logic              rx_valid,
  output logic              rx_ready
);
  localparam int IW = ADDR_W - 2;

  logic [IW-1:0] word_idx;
  logic aligned, wr, rd;
  logic hit_lctl, hit_lsts, hit_ictl, hit_ists, hit_fctl, hit_baud, hit_txd, hit_rxd;

  assign word_idx = bus_addr[ADDR_W-1:2];
  assign aligned  = (bus_addr[1:0] == 2'b00);
  assign wr       = bus_sel && bus_we && aligned;
  assign rd       = bus_sel && !bus_we && aligned;
  assign hit_lctl = (word_idx == IW'(IDX_LINE_CTL));
  assign hit_lsts = (word_idx == IW'(IDX_LINE_STS));
  assign hit_ictl = (word_idx == IW'(IDX_INT_CTL));
  assign hit_ists = (word_idx == IW'(IDX_INT_STS));
  assign hit_fctl = (word_idx == IW'(IDX_FIFO_CTL));
  assign hit_baud = (word_idx == IW'(IDX_BAUD));
  assign hit_txd  = (word_idx == IW'(IDX_TX_DATA));
  assign hit_rxd  = (word_idx == IW'(IDX_RX_DATA));

  logic [WORD_W-1:0] lctl_q, fctl_q, baud_q, fctl_d, ictl_q, ists_q;
  logic tx_ovf_q;

  assign fctl_d = merge_lanes(fctl_q, bus_wdata, bus_be, MASK_FIFO_CTL);

  // queue control
  logic tx_flush, rx_flush, tx_push, tx_drop, rx_pop, rx_push;
  logic tx_empty, tx_full, rx_empty, rx_full;
  logic [7:0] rx_head;

  assign tx_flush = wr && hit_fctl && fctl_d[BIT_FRST_EN] && fctl_d[BIT_TX_FLUSH];
  assign rx_flush = wr && hit_fctl && fctl_d[BIT_FRST_EN] && fctl_d[BIT_RX_FLUSH];
  assign tx_push  = wr && hit_txd && bus_be[LANES-1];
  assign tx_drop  = tx_push && tx_full;
  assign rx_pop   = rd && hit_rxd && bus_be[LANES-1];
  assign rx_push  = rx_valid && rx_ready;
  assign tx_valid = !tx_empty;
  assign rx_ready = !rx_full;

  sio_byte_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) tx_fifo_i (
    .clk(clk), .rst(rst), .flush(tx_flush),
    .push(tx_push), .push_data(bus_wdata[WORD_W-1 -: 8]),
    .pop(tx_valid && tx_ready),
    .head(tx_data), .empty(tx_empty), .full(tx_full));

  sio_byte_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) rx_fifo_i (
    .clk(clk), .rst(rst), .flush(rx_flush),
    .push(rx_push), .push_data(rx_data),
    .pop(rx_pop),
    .head(rx_head), .empty(rx_empty), .full(rx_full));

  sio_irq_unit irq_i (
    .clk(clk), .rst(rst),
    .ctl_wr(wr && hit_ictl), .sts_wr(wr && hit_ists),
    .wdata(bus_wdata), .be(bus_be),
    .rx_has_data(!rx_empty), .tx_is_empty(tx_empty),
    .ctl_q(ictl_q), .sts_q(ists_q), .irq(irq), .dma_err(dma_err));

  // plain configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      lctl_q   <= RST_LINE_CTL;
      fctl_q   <= '0;
      baud_q   <= RST_BAUD;
      tx_ovf_q <= 1'b0;
    end else begin
      if (wr && hit_lctl) lctl_q <= merge_lanes(lctl_q, bus_wdata, bus_be, MASK_LINE_CTL);
      if (wr && hit_fctl) fctl_q <= fctl_d;
      if (wr && hit_baud) baud_q <= merge_lanes(baud_q, bus_wdata, bus_be, MASK_BAUD);
      if (tx_flush)       tx_ovf_q <= 1'b0;
      else if (tx_drop)   tx_ovf_q <= 1'b1;
    end
  end

  // registered read port
  logic [WORD_W-1:0] rd_val;
  always_comb begin
    rd_val = '0;
    if (hit_lctl)      rd_val = lctl_q;
    else if (hit_lsts) rd_val = {{(WORD_W-1){1'b0}}, tx_ovf_q};
    else if (hit_ictl) rd_val = ictl_q;
    else if (hit_ists) rd_val = ists_q;
    else if (hit_fctl) rd_val = fctl_q;
    else if (hit_baud) rd_val = baud_q;
    else if (hit_rxd && bus_be[LANES-1] && !rx_empty)
      rd_val = {rx_head, {(WORD_W-8){1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd ? rd_val : '0;
  end

  assert_tx_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready && !tx_flush) |=> (tx_valid && $stable(tx_data)));
  assert_line_status_ro_R2: assert property (@(posedge clk) disable iff (rst)
    (wr && hit_lsts && !tx_drop && !tx_flush) |=> $stable(tx_ovf_q));
endmodule

// File: tb/sio_port_regs_tb.sv
module sio_port_regs_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_sel = 1'b0, bus_we = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [3:0] bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq, dma_err, tx_valid, rx_ready;
  logic [7:0] tx_data;
  logic tx_ready = 1'b0;
  logic [7:0] rx_data = '0;
  logic rx_valid = 1'b0;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;  // 50 MHz

  sio_port_regs dut_i (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .dma_err(dma_err), .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready));

  // row: we | addr | be | wdata | expected | requirement number
  localparam int NV = 29;
  localparam logic [80:0] VEC [NV] = '{
    {1'b0, 8'h00, 4'hF, 32'h0, 32'h4000_0000, 4'd1},   // R1 line control reset
    {1'b0, 8'h14, 4'hF, 32'h0, 32'h03FF_0000, 4'd1},   // R1 baud reset
    {1'b0, 8'h04, 4'hF, 32'h0, 32'h0,         4'd1},   // R1 line status reset
    {1'b0, 8'h10, 4'hF, 32'h0, 32'h0,         4'd1},   // R1 fifo control reset
    {1'b0, 8'h08, 4'hF, 32'h0, 32'h0,         4'd1},   // R1 interrupt control reset
    {1'b1, 8'h00, 4'hF, 32'hFFFF_FFFF, 32'h0, 4'd2},
    {1'b0, 8'h00, 4'hF, 32'h0, 32'hE17F_0000, 4'd2},   // R2 line control mask
    {1'b1, 8'h14, 4'hF, 32'hFFFF_FFFF, 32'h0, 4'd2},
    {1'b0, 8'h14, 4'hF, 32'h0, 32'h03FF_0000, 4'd2},   // R2 baud mask
    {1'b1, 8'h04, 4'hF, 32'hFFFF_FFFF, 32'h0, 4'd2},
    {1'b0, 8'h04, 4'hF, 32'h0, 32'h0,         4'd2},   // R2 line status read-only
    {1'b1, 8'h0C, 4'hF, 32'hFFFF_FFFF, 32'h0, 4'd2},
    {1'b0, 8'h0C, 4'hF, 32'h0, 32'h0007_0000, 4'd2},   // R2 status mask
    {1'b1, 8'h0C, 4'hF, 32'h0, 32'h0,         4'd6},
    {1'b0, 8'h0C, 4'hF, 32'h0, 32'h0002_0000, 4'd6},   // R6 tx-empty re-set
    {1'b1, 8'h00, 4'h8, 32'h00AA_BBCC, 32'h0, 4'd3},
    {1'b0, 8'h00, 4'hF, 32'h0, 32'h007F_0000, 4'd3},   // R3 top lane only
    {1'b1, 8'h00, 4'h4, 32'hFF12_FFFF, 32'h0, 4'd3},
    {1'b0, 8'h00, 4'hF, 32'h0, 32'h0012_0000, 4'd3},   // R3 second lane only
    {1'b1, 8'h10, 4'hF, 32'hFFFF_FFFF, 32'h0, 4'd2},
    {1'b0, 8'h10, 4'hF, 32'h0, 32'h001F_0000, 4'd2},   // R2 fifo control mask
    {1'b1, 8'h10, 4'hF, 32'h0, 32'h0,         4'd2},
    {1'b0, 8'h20, 4'hF, 32'h0, 32'h0,         4'd4},   // R4 tx data reads zero
    {1'b0, 8'h30, 4'hF, 32'h0, 32'h0,         4'd5},   // R5 empty rx reads zero
    {1'b1, 8'h40, 4'hF, 32'hFFFF_FFFF, 32'h0, 4'd13},
    {1'b0, 8'h40, 4'hF, 32'h0, 32'h0,         4'd13},  // R13 unmapped
    {1'b0, 8'h02, 4'hF, 32'h0, 32'h0,         4'd13},  // R13 misaligned read
    {1'b1, 8'h02, 4'hF, 32'hFFFF_FFFF, 32'h0, 4'd13},
    {1'b0, 8'h00, 4'hF, 32'h0, 32'h0012_0000, 4'd13}   // R13 misaligned write ignored
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, input logic [3:0] be, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a; bus_be = be;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rx_send(input logic [7:0] b);
    @(negedge clk);
    rx_data = b; rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  // drain n bytes starting at first, checking order
  task automatic tx_drain(input int n, input logic [7:0] first, input string tag);
    for (int k = 0; k < n; k++) begin
      chk(tag, {24'h0, tx_data}, {24'h0, first + 8'(k)});
      tx_ready = 1'b1;
      @(negedge clk);
    end
    tx_ready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 outputs after reset
    chk("R1 irq", {31'h0, irq}, 32'h0);
    chk("R1 dma_err", {31'h0, dma_err}, 32'h0);
    chk("R1 tx_valid", {31'h0, tx_valid}, 32'h0);
    chk("R1 rx_ready", {31'h0, rx_ready}, 32'h1);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][80]) bus_wr(VEC[i][79:72], VEC[i][71:68], VEC[i][67:36]);
      else begin
        bus_rd(VEC[i][79:72], VEC[i][71:68], r);
        chk($sformatf("R%0d vector %0d", VEC[i][3:0], i), r, VEC[i][35:4]);
      end
    end

    // R4 / R10: pushes, ignored lane, ordered drain
    bus_wr(8'h20, 4'h8, 32'h11FF_FFFF);
    bus_wr(8'h20, 4'h7, 32'h0099_9999);
    bus_wr(8'h20, 4'h8, 32'h1200_0000);
    bus_wr(8'h20, 4'h8, 32'h1300_0000);
    chk("R10 tx_valid", {31'h0, tx_valid}, 32'h1);
    tx_drain(3, 8'h11, "R10 tx order");
    chk("R4 ignored lane pushed nothing", {31'h0, tx_valid}, 32'h0);

    // R9 overflow
    for (int k = 0; k < 9; k++) bus_wr(8'h20, 4'h8, {8'h40 + 8'(k), 24'h0});
    bus_rd(8'h04, 4'hF, r);
    chk("R9 overflow flag", r, 32'h1);
    tx_drain(8, 8'h40, "R9 ninth byte dropped");
    chk("R9 empty after 8", {31'h0, tx_valid}, 32'h0);
    bus_rd(8'h04, 4'hF, r);
    chk("R9 flag sticky", r, 32'h1);

    // R8 reset gating
    bus_wr(8'h20, 4'h8, 32'h5500_0000);
    bus_wr(8'h10, 4'hF, 32'h0006_0000);
    chk("R8 no enable keeps tx", {31'h0, tx_valid}, 32'h1);
    bus_wr(8'h10, 4'hF, 32'h0003_0000);
    chk("R8 rx reset keeps tx", {31'h0, tx_valid}, 32'h1);
    bus_wr(8'h10, 4'hF, 32'h0005_0000);
    chk("R8 tx reset empties", {31'h0, tx_valid}, 32'h0);
    bus_rd(8'h04, 4'hF, r);
    chk("R9 flag cleared by tx reset", r, 32'h0);

    // R5 / R11 receive path
    rx_send(8'hA1);
    rx_send(8'hA2);
    bus_rd(8'h30, 4'h7, r);
    chk("R5 no top lane returns zero", r, 32'h0);
    bus_rd(8'h30, 4'h8, r);
    chk("R5 pop first", r, 32'hA100_0000);
    bus_rd(8'h30, 4'h8, r);
    chk("R5 pop second", r, 32'hA200_0000);
    bus_rd(8'h30, 4'h8, r);
    chk("R5 pop empty", r, 32'h0);
    for (int k = 0; k < 8; k++) rx_send(8'hB0 + 8'(k));
    chk("R11 full drops ready", {31'h0, rx_ready}, 32'h0);
    bus_rd(8'h30, 4'h8, r);
    chk("R11 order kept", r, 32'hB000_0000);
    chk("R11 ready returns", {31'h0, rx_ready}, 32'h1);
    bus_wr(8'h10, 4'hF, 32'h0003_0000);
    bus_rd(8'h30, 4'h8, r);
    chk("R8 rx reset empties", r, 32'h0);

    // R6 / R7 interrupt
    bus_wr(8'h0C, 4'hF, 32'h0);
    bus_rd(8'h0C, 4'hF, r);
    chk("R6 rx flag cleared", r, 32'h0002_0000);
    bus_wr(8'h08, 4'hF, 32'h0001_0000);
    chk("R7 irq low, rx flag clear", {31'h0, irq}, 32'h0);
    rx_send(8'h5A);
    @(negedge clk);
    chk("R7 irq on rx data", {31'h0, irq}, 32'h1);
    bus_rd(8'h30, 4'h8, r);
    chk("R5 pop 5A", r, 32'h5A00_0000);
    @(negedge clk);
    chk("R6 flag sticky after pop", {31'h0, irq}, 32'h1);
    bus_wr(8'h0C, 4'hF, 32'h0);
    chk("R7 irq clears on status write", {31'h0, irq}, 32'h0);
    bus_wr(8'h08, 4'hF, 32'h0002_0000);
    chk("R7 irq on tx-empty enable", {31'h0, irq}, 32'h1);
    bus_wr(8'h08, 4'hF, 32'h0);
    chk("R7 irq clears on enable write", {31'h0, irq}, 32'h0);

    // R12 DMA request flag
    bus_wr(8'h08, 4'hF, 32'h0008_0000);
    chk("R12 dma_err set", {31'h0, dma_err}, 32'h1);
    bus_rd(8'h08, 4'hF, r);
    chk("R12 control readback", r, 32'h0008_0000);
    bus_wr(8'h08, 4'hF, 32'h0);
    chk("R12 dma_err clear", {31'h0, dma_err}, 32'h0);

    // same-cycle stream push and bus pop on the receive queue (R11, R5)
    rx_send(8'h61);
    @(negedge clk);
    rx_data = 8'h62; rx_valid = 1'b1;
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 8'h30; bus_be = 4'h8;
    @(negedge clk);
    rx_valid = 1'b0; bus_sel = 1'b0;
    chk("R5 collide pop old head", bus_rdata, 32'h6100_0000);
    bus_rd(8'h30, 4'h8, r);
    chk("R11 collide push kept", r, 32'h6200_0000);
    bus_rd(8'h30, 4'h8, r);
    chk("R11 collide then empty", r, 32'h0);

    // same-cycle bus push and stream pop on the transmit queue (R4, R10)
    bus_wr(8'h20, 4'h8, 32'h7100_0000);
    @(negedge clk);
    tx_ready = 1'b1;
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 8'h20; bus_be = 4'h8; bus_wdata = 32'h7200_0000;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; tx_ready = 1'b0;
    chk("R10 collide valid", {31'h0, tx_valid}, 32'h1);
    chk("R4 collide new head", {24'h0, tx_data}, 32'h72);
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
    chk("R10 collide then empty", {31'h0, tx_valid}, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule